// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 64 words of 9 bits. The write side and the read side each run on their own clock, and the two clocks need have no relation to each other. The write side accepts a word when both of its enables are active. The read side returns the oldest word when both of its enables are active. Each pointer crosses into the other clock domain in Gray code through a two-stage synchronizer.

The block drives four active-low status outputs. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock. The almost-empty and almost-full thresholds are held in two offset registers, and both reset to 7.

The second write-enable input has two possible roles, and its level while reset is held picks the role. If it is high during reset, it is a plain active-high write enable. If it is low during reset, it becomes a load strobe. While the load strobe is low, write cycles fill the two offset registers, and read cycles return the offsets on the data output. An output-enable input forces the data output to zero while it is high.

Top module: `dc_fifo_pf`

## Requirements
- R1: While rst_ni is low, and after it is released, the outputs are as follows until the first access: empty_no = 0, almost_empty_no = 0, full_no = 1, almost_full_no = 1 and data_o = 0. Both offset registers reset to 7.
- R2: Words leave in the order they were written. A read at a rising rclk_i edge places the oldest stored word on data_o directly after that edge.
- R3: full_no is low exactly when 64 words are stored. While full_no is low, a write cycle stores nothing and the word is lost. full_no changes only at rising wclk_i edges.
- R4: empty_no is low exactly when no word is stored. While empty_no is low, a read cycle leaves data_o unchanged. empty_no changes only at rising rclk_i edges.
- R5: almost_empty_no is low when the stored count is less than or equal to the almost-empty offset. It is registered on rclk_i.
- R6: almost_full_no is low when the free space (64 minus the count) is less than or equal to the almost-full offset. It is registered on wclk_i.
- R7: If wen2_ld_i is high while rst_ni is low, a word is written only when wen1_ni is low, wen2_ld_i is high and full_no is high. A read happens only when ren1_ni and ren2_ni are both low and empty_no is high.
- R8: If wen2_ld_i is low while rst_ni is low, load mode is selected. In load mode, a wclk_i edge with wen1_ni low and wen2_ld_i low writes data_i[5:0] into an offset register. The targets go almost-empty offset first, then almost-full offset, and then back to the start. With wen2_ld_i high, FIFO writes and reads behave as in R7.
- R9: In load mode, an rclk_i edge with ren1_ni low and wen2_ld_i low places the next offset on data_o[5:0], with data_o[8:6] = 0. Offsets are returned in the same order as R8, and no FIFO word is consumed.
- R10: While oe_ni is high, data_o reads 0. When oe_ni returns low, the held output word reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wen1_ni | input | 1 | First write enable, active low |
| wen2_ld_i | input | 1 | Second write enable (active high), or load strobe (active low) in load mode |
| data_i | input | 9 | Write data; bits 5:0 carry offsets in load mode |
| ren1_ni | input | 1 | First read enable, active low |
| ren2_ni | input | 1 | Second read enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 9 | Read data or offset read-back |
| empty_no | output | 1 | Empty flag, active low, rclk_i domain |
| almost_empty_no | output | 1 | Almost-empty flag, active low, rclk_i domain |
| full_no | output | 1 | Full flag, active low, wclk_i domain |
| almost_full_no | output | 1 | Almost-full flag, active low, wclk_i domain |

## Verification
The assertions check four properties on every edge of the matching clock:
- the write pointer does not move while full is flagged;
- the read pointer does not move while empty is flagged;
- the data output holds while empty is flagged;
- each extreme flag implies its almost flag.

The bench scenarios cover the rest: FIFO ordering across the pointer synchronizers, the exact boundary counts of both threshold flags, mode selection by the level at reset, offset load and read-back order with wrap, and output blanking.

// File: rtl/dc_fifo_pkg.sv
package dc_fifo_pkg;
  typedef enum logic {OFS_AE = 1'b0, OFS_AF = 1'b1} ofs_sel_e;
  localparam int unsigned DEF_OFS = 7;
endpackage

// File: rtl/dc_fifo_gsync.sv
// Two-stage Gray synchronizer with binary reconstruction
module dc_fifo_gsync #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/dc_fifo_mem.sv
module dc_fifo_mem #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 6
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dc_fifo_wr.sv
// Write side: pointer, full / almost-full flags, offset registers
module dc_fifo_wr
  import dc_fifo_pkg::*;
#(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen1_ni,
  input  logic          wen2_ld_i,
  input  logic          ld_mode_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW:0]   rptr_bin_i,
  output logic          wr_en_o,
  output logic [AW:0]   wptr_bin_o,
  output logic [AW:0]   wptr_gray_o,
  output logic          full_no,
  output logic          almost_full_no,
  output logic [AW-1:0] ae_ofs_o,
  output logic [AW-1:0] af_ofs_o
);
  localparam logic [AW:0]   DEPTH_P = {1'b1, {AW{1'b0}}};
  localparam logic [AW-1:0] OFS_RST = AW'(DEF_OFS);

  logic [AW:0] wbin_q, wbin_nxt, cnt_nxt, free_nxt;
  logic        fifo_req, ofs_wr;
  ofs_sel_e    sel_q;

  // Write enable shares one expression in both modes: LD high acts as WEN2
  assign fifo_req = !wen1_ni && wen2_ld_i;
  assign ofs_wr   = ld_mode_i && !wen1_ni && !wen2_ld_i;
  assign wr_en_o  = fifo_req && full_no;
  assign wbin_nxt = wbin_q + (AW+1)'(wr_en_o);
  assign cnt_nxt  = wbin_nxt - rptr_bin_i;
  assign free_nxt = DEPTH_P - cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q         <= '0;
      wptr_gray_o    <= '0;
      full_no        <= 1'b1;
      almost_full_no <= 1'b1;
    end else begin
      wbin_q         <= wbin_nxt;
      wptr_gray_o    <= wbin_nxt ^ (wbin_nxt >> 1);
      full_no        <= (cnt_nxt != DEPTH_P);
      almost_full_no <= !(free_nxt <= {1'b0, af_ofs_o});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_ofs_o <= OFS_RST;
      af_ofs_o <= OFS_RST;
      sel_q    <= OFS_AE;
    end else if (ofs_wr) begin
      if (sel_q == OFS_AE) ae_ofs_o <= data_i[AW-1:0];
      else                 af_ofs_o <= data_i[AW-1:0];
      sel_q <= (sel_q == OFS_AE) ? OFS_AF : OFS_AE;
    end
  end

  assign wptr_bin_o = wbin_q;
endmodule

// File: rtl/dc_fifo_rd.sv
// Read side: pointer, empty / almost-empty flags, output register, offset read-back
module dc_fifo_rd
  import dc_fifo_pkg::*;
#(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren1_ni,
  input  logic          ren2_ni,
  input  logic          ld_i,
  input  logic          ld_mode_i,
  input  logic [AW:0]   wptr_bin_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW-1:0] af_ofs_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rptr_bin_o,
  output logic [AW:0]   rptr_gray_o,
  output logic          empty_no,
  output logic          almost_empty_no,
  output logic [DW-1:0] q_o
);
  logic [AW:0] rbin_q, rbin_nxt, cnt_nxt;
  logic        fifo_req, rd_en, ofs_rd;
  ofs_sel_e    sel_q;

  // Offsets are quasi-static configuration; read here without a synchronizer
  assign fifo_req = !ren1_ni && !ren2_ni && (!ld_mode_i || ld_i);
  assign rd_en    = fifo_req && empty_no;
  assign ofs_rd   = ld_mode_i && !ld_i && !ren1_ni;
  assign rbin_nxt = rbin_q + (AW+1)'(rd_en);
  assign cnt_nxt  = wptr_bin_i - rbin_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q          <= '0;
      rptr_gray_o     <= '0;
      empty_no        <= 1'b0;
      almost_empty_no <= 1'b0;
    end else begin
      rbin_q          <= rbin_nxt;
      rptr_gray_o     <= rbin_nxt ^ (rbin_nxt >> 1);
      empty_no        <= (cnt_nxt != '0);
      almost_empty_no <= !(cnt_nxt <= {1'b0, ae_ofs_i});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      sel_q <= OFS_AE;
    end else if (rd_en) begin
      q_o <= mem_rdata_i;
    end else if (ofs_rd) begin
      q_o   <= DW'((sel_q == OFS_AE) ? ae_ofs_i : af_ofs_i);
      sel_q <= (sel_q == OFS_AE) ? OFS_AF : OFS_AE;
    end
  end

  assign raddr_o    = rbin_q[AW-1:0];
  assign rptr_bin_o = rbin_q;
endmodule

// File: rtl/dc_fifo_pf.sv
module dc_fifo_pf #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 6
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen1_ni,
  input  logic          wen2_ld_i,
  input  logic [DW-1:0] data_i,
  input  logic          ren1_ni,
  input  logic          ren2_ni,
  input  logic          oe_ni,
  output logic [DW-1:0] data_o,
  output logic          empty_no,
  output logic          almost_empty_no,
  output logic          full_no,
  output logic          almost_full_no
);
  logic          ld_mode_q, wr_en;
  logic [AW:0]   wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [AW:0]   rptr_bin_ws, wptr_bin_rs;
  logic [AW-1:0] ae_ofs, af_ofs, raddr;
  logic [DW-1:0] mem_rdata, q;

  // Role of wen2_ld_i is sampled on wclk while reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) ld_mode_q <= !wen2_ld_i;
  end

  dc_fifo_wr #(.DW(DW), .AW(AW)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen1_ni(wen1_ni), .wen2_ld_i(wen2_ld_i),
    .ld_mode_i(ld_mode_q), .data_i(data_i), .rptr_bin_i(rptr_bin_ws),
    .wr_en_o(wr_en), .wptr_bin_o(wptr_bin), .wptr_gray_o(wptr_gray),
    .full_no(full_no), .almost_full_no(almost_full_no),
    .ae_ofs_o(ae_ofs), .af_ofs_o(af_ofs)
  );

  dc_fifo_gsync #(.W(AW+1)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rptr_gray), .bin_o(rptr_bin_ws)
  );

  dc_fifo_gsync #(.W(AW+1)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wptr_gray), .bin_o(wptr_bin_rs)
  );

  dc_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i(wclk_i), .we_i(wr_en), .waddr_i(wptr_bin[AW-1:0]), .wdata_i(data_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  dc_fifo_rd #(.DW(DW), .AW(AW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .ren1_ni(ren1_ni), .ren2_ni(ren2_ni),
    .ld_i(wen2_ld_i), .ld_mode_i(ld_mode_q), .wptr_bin_i(wptr_bin_rs),
    .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs), .mem_rdata_i(mem_rdata),
    .raddr_o(raddr), .rptr_bin_o(rptr_bin), .rptr_gray_o(rptr_gray),
    .empty_no(empty_no), .almost_empty_no(almost_empty_no), .q_o(q)
  );

  assign data_o = oe_ni ? '0 : q;
endmodule

// File: rtl/dc_fifo_pf_chk.sv
module dc_fifo_pf_chk #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 6
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen2_ld_i,
  input logic          oe_ni,
  input logic [DW-1:0] data_o,
  input logic          empty_no,
  input logic          almost_empty_no,
  input logic          full_no,
  input logic          almost_full_no,
  input logic [AW:0]   wptr_i,
  input logic [AW:0]   rptr_i
);
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wptr_i)); // R3
  AST_FULL_IMPLIES_AF: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !almost_full_no); // R6
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> $stable(rptr_i)); // R4
  AST_Q_HOLD_WHEN_EMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && wen2_ld_i && !oe_ni) |=> (oe_ni || $stable(data_o))); // R4
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !almost_empty_no); // R5
endmodule

bind dc_fifo_pf dc_fifo_pf_chk #(.DW(DW), .AW(AW)) chk_i (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .wen2_ld_i(wen2_ld_i),
  .oe_ni(oe_ni), .data_o(data_o), .empty_no(empty_no),
  .almost_empty_no(almost_empty_no), .full_no(full_no),
  .almost_full_no(almost_full_no), .wptr_i(wptr_bin), .rptr_i(rptr_bin)
);

// File: tb/dc_fifo_pf_tb_top.sv
module dc_fifo_pf_tb_top;
  localparam int DEPTH = 64;

  logic wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic wen1_ni = 1'b1, wen2_ld_i = 1'b1, ren1_ni = 1'b1, ren2_ni = 1'b1, oe_ni = 1'b0;
  logic [8:0] data_i = '0;
  logic [8:0] data_o;
  logic empty_no, almost_empty_no, full_no, almost_full_no;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] model_q[$];
  int ae_ofs = 7, af_ofs = 7;
  logic [8:0] exp_q;
  bit exp_valid = 0;
  int popped = 0;

  always #5 wclk = ~wclk;   // 100 MHz write clock
  always #7 rclk = ~rclk;   // unrelated read clock

  dc_fifo_pf dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .wen1_ni(wen1_ni),
    .wen2_ld_i(wen2_ld_i), .data_i(data_i), .ren1_ni(ren1_ni), .ren2_ni(ren2_ni),
    .oe_ni(oe_ni), .data_o(data_o), .empty_no(empty_no),
    .almost_empty_no(almost_empty_no), .full_no(full_no),
    .almost_full_no(almost_full_no)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic ld_level);
    rst_ni = 1'b0; wen2_ld_i = ld_level; wen1_ni = 1'b1;
    ren1_ni = 1'b1; ren2_ni = 1'b1; oe_ni = 1'b0;
    repeat (4) @(posedge wclk);
    @(negedge wclk);
    rst_ni = 1'b1;
    wen2_ld_i = 1'b1;
    model_q.delete();
    ae_ofs = 7; af_ofs = 7; exp_valid = 0;
  endtask

  task automatic wr_cycle(input bit en, input logic [8:0] d);
    @(negedge wclk);
    wen1_ni = !en; data_i = d;
    if (en && full_no) model_q.push_back(d);
  endtask

  task automatic wr_idle();
    @(negedge wclk);
    wen1_ni = 1'b1;
  endtask

  task automatic rd_cycle(input bit en);
    @(negedge rclk);
    if (exp_valid) check("R2/R4 data", int'(data_o), int'(exp_q));
    ren1_ni = !en; ren2_ni = !en;
    if (en && empty_no) begin
      exp_q = model_q.pop_front();
      popped++;
    end else begin
      exp_q = data_o;
    end
    exp_valid = 1;
  endtask

  task automatic rd_idle();
    @(negedge rclk);
    if (exp_valid) check("R2/R4 data", int'(data_o), int'(exp_q));
    ren1_ni = 1'b1; ren2_ni = 1'b1;
    exp_valid = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge wclk);
  endtask

  task automatic check_flags(input string tag);
    int n = model_q.size();
    check({"R4 empty ", tag}, int'(empty_no), int'(n != 0));
    check({"R3 full ", tag}, int'(full_no), int'(n != DEPTH));
    check({"R5 almost_empty ", tag}, int'(almost_empty_no), int'(!(n <= ae_ofs)));
    check({"R6 almost_full ", tag}, int'(almost_full_no), int'(!((DEPTH - n) <= af_ofs)));
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) wr_cycle(1, 9'($urandom));
    wr_idle();
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH + 8; i++) rd_cycle(1);
    rd_idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    do_reset(1'b1);
    // R1 reset state
    check("R1 empty_no", int'(empty_no), 0);
    check("R1 almost_empty_no", int'(almost_empty_no), 0);
    check("R1 full_no", int'(full_no), 1);
    check("R1 almost_full_no", int'(almost_full_no), 1);
    check("R1 data_o", int'(data_o), 0);

    // R7 wen2 low in normal mode blocks writes
    @(negedge wclk); wen1_ni = 1'b0; wen2_ld_i = 1'b0; data_i = 9'h1aa;
    @(negedge wclk); wen1_ni = 1'b1; wen2_ld_i = 1'b1;
    settle();
    check("R7 no write with wen2 low", int'(empty_no), 0);

    // R5 boundary at default offset 7
    write_n(7); settle(); check_flags("count 7");
    write_n(1); settle(); check_flags("count 8");
    // R6 boundary: 56 then 57 words
    write_n(48); settle(); check_flags("count 56");
    write_n(1); settle(); check_flags("count 57");
    // R3 fill past full: extra words dropped
    write_n(10); settle(); check_flags("full");
    check("R3 stored count", model_q.size(), DEPTH);

    // R10 output blanking
    rd_cycle(1); rd_cycle(0); rd_idle();
    @(negedge rclk); oe_ni = 1'b1;
    @(negedge rclk); check("R10 blanked", int'(data_o), 0);
    oe_ni = 1'b0;
    @(negedge rclk); check("R10 restored", int'(data_o), int'(exp_q));

    popped = 1;
    drain(); settle();
    check("R3 words drained", popped, DEPTH);
    check_flags("drained");
    // R4 reads while empty leave output unchanged
    for (int i = 0; i < 4; i++) rd_cycle(1);
    rd_idle();

    // random traffic, R2
    fork
      begin
        for (int i = 0; i < 600; i++) wr_cycle($urandom_range(0, 2) != 0, 9'($urandom));
        wr_idle();
      end
      begin
        for (int i = 0; i < 500; i++) rd_cycle($urandom_range(0, 1) != 0);
        rd_idle();
      end
    join
    settle(); check_flags("after random");
    drain(); settle(); check_flags("random drained");

    // Load mode, R8 / R9
    do_reset(1'b0);
    check("R1 load-mode empty_no", int'(empty_no), 0);
    @(negedge wclk); wen1_ni = 1'b0; wen2_ld_i = 1'b0; data_i = 9'h103;
    @(negedge wclk); data_i = 9'h005;
    @(negedge wclk); data_i = 9'h1c4;
    @(negedge wclk); wen1_ni = 1'b1;
    ae_ofs = 4; af_ofs = 5;
    @(negedge rclk); ren1_ni = 1'b0;
    @(negedge rclk); check("R9 readback ae", int'(data_o), 4);
    @(negedge rclk); check("R9 readback af", int'(data_o), 5);
    @(negedge rclk); check("R9 readback wrap", int'(data_o), 4);
    ren1_ni = 1'b1;
    @(negedge wclk); wen2_ld_i = 1'b1;
    settle();
    check("R8 no fifo word from load", int'(empty_no), 0);
    write_n(4); settle(); check_flags("R8 count 4");
    write_n(1); settle(); check_flags("R8 count 5");
    write_n(53); settle(); check_flags("R8 count 58");
    write_n(1); settle(); check_flags("R8 count 59");
    popped = 0;
    drain(); settle();
    check("R8 load-mode drain", popped, 59);
    check_flags("R8 drained");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule